// File: doc/BRIEF.md
# SCSI Controller Host Register File

This block is the byte-wide register window that a host processor uses to drive a SCSI protocol controller. Each address has a read view and a write view, and the two are not always the same storage. The transfer counter is the clearest case. Software writes a staging copy of the 24-bit count, and the readable copy takes that value only when a command byte with its DMA flag set is issued. A 16-byte data FIFO is filled through a data register and drained through the same address. Its fill level appears in a flags register.

Command bytes that need no bus activity are executed inside the block:
- no-op
- FIFO flush
- chip reset
- bus reset
- message accept
- pad
- enable selection
- disable selection

Commands that start selection or information transfer are forwarded as a single-cycle pulse to an external sequencer, together with their opcode and DMA flag. Interrupts are reported through an interrupt register and a level output. Reading the interrupt register acknowledges it: it clears the report, clears terminal count, forces the sequence step to "command done" and drops the line.

The host bus is a plain register port. It never stalls, and every access completes in the cycle it is presented. Read data is combinational from the current state, and any side effect of the read takes place at the closing clock edge. The register index is the bus address shifted right by the `SHIFT` parameter.

Top module: `scsi_host_regs`

## Requirements

Indices are after the address shift:
- 0, 1, 2: counter low, middle and high bytes
- 3: FIFO
- 4: command
- 5: status
- 6: interrupt
- 7: sequence step
- 8: FIFO flags
- 9: configuration

Indices 10 and above read 0, and writes to them are ignored.

Status bit 7 is the interrupt-pending bit and bit 4 is terminal count. The opcode is held in command bits 6:0, and bit 7 is the DMA flag.

Interrupt codes:

| Code | Meaning |
|------|---------|
| 0x08 | function complete |
| 0x20 | disconnect |
| 0x80 | reset |

Command opcodes:

| Opcode | Command |
|--------|---------|
| 0x00 | no-op |
| 0x01 | flush |
| 0x02 | chip reset |
| 0x03 | bus reset |
| 0x10 | transfer information |
| 0x12 | message accept |
| 0x18 | pad |
| 0x41 | select without attention |
| 0x42 | select with attention |
| 0x43 | select with attention and stop |
| 0x44 | enable selection |
| 0x45 | disable selection |

- R1: After reset, every register reads 0 except counter-high, which reads the `CHIP_ID` parameter (default 0x5A), and configuration, which reads 0x07. The `irq` output is low.
- R2: Counter writes land in a staging copy, and the readable counter bytes do not change. A command byte with bit 7 set copies all three staging bytes into the readable bytes, low byte at index 0.
- R3: FIFO writes at index 3 are read back at index 3 in first-in first-out order. Each read pops one byte, and a read of an empty FIFO returns 0. Bits 4:0 of the flags register hold the byte count.
- R4: A FIFO write while the FIFO holds 15 bytes is an overrun: the byte is dropped and the count stays 15.
- R5: A byte read of the interrupt register returns its current value. At that clock edge it clears the interrupt register and status bits 7 and 4, and sets the sequence step to 4. `irq` is low from the next cycle.
- R6: `irq` equals status bit 7. It rises only after a command write that reports an interrupt.
- R7: Flush (0x01) sets the interrupt register to 0x08, clears the sequence step and empties the FIFO, and raises `irq`.
- R8: Bus reset (0x03) sets the interrupt register to 0x80. It raises `irq` only when configuration bit 6 is 0.
- R9: Message accept (0x12) sets the interrupt register to 0x20, clears the sequence step and empties the FIFO, and raises `irq`.
- R10: Pad (0x18) sets status to 0x90 (terminal count plus interrupt), the interrupt register to 0x08 and the sequence step to 0. Any other command write clears status bit 4.
- R11: Chip reset (0x02) returns every register and the FIFO to the R1 state.
- R12: Enable selection (0x44) and disable selection (0x45) clear the interrupt register without raising `irq`. Opcodes 0x10, 0x41, 0x42 and 0x43 give a one-cycle `seq_start` pulse in the cycle after the write, with `seq_op` holding the opcode and `seq_dma` holding bit 7.
- R13: The register index is `bus_addr >> SHIFT`. With `acc_wide` high, a write behaves as a byte write of `wdata`. A read with `acc_wide` high is rejected: `rdata` is 0 and nothing changes.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; the register index is this value shifted right by SHIFT |
| wr_en | input | 1 | Write strobe; wins over rd_en |
| rd_en | input | 1 | Read strobe |
| acc_wide | input | 1 | High for a 4-byte access; accepted for writes only |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from current state |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| seq_start | output | 1 | One-cycle pulse for a sequencer command |
| seq_op | output | 7 | Opcode of the last sequencer command |
| seq_dma | output | 1 | DMA flag of the last sequencer command |

## Verification

Internal faults in this block surface at the ports within one access:
- A corrupted staging or readable counter byte shows on the very next counter read after a DMA-flagged command.
- A stuck FIFO pointer shows as out-of-order or repeated bytes on the following pops, and as a wrong count in the flags register.
- A missed acknowledge side effect leaves `irq` high one cycle after an interrupt read, or a nonzero value on a second interrupt read. A wrong sequence-step code shows on the next sequence read.
- Random interleaving of counter, FIFO and command traffic exposes state that leaks between these paths.

// File: rtl/scsi_regs_pkg.sv
`timescale 1ns/1ps
package scsi_regs_pkg;

  localparam int CNT_BYTES = 3;

  typedef enum logic [3:0] {
    RI_CNT_LO  = 4'd0,
    RI_CNT_MID = 4'd1,
    RI_CNT_HI  = 4'd2,
    RI_FIFO    = 4'd3,
    RI_CMD     = 4'd4,
    RI_STATUS  = 4'd5,
    RI_INTR    = 4'd6,
    RI_SEQ     = 4'd7,
    RI_FLAGS   = 4'd8,
    RI_CFG1    = 4'd9
  } reg_idx_e;

  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIP_RST = 7'h02;
  localparam logic [6:0] OP_BUS_RST  = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_MSG_ACC  = 7'h12;
  localparam logic [6:0] OP_PAD      = 7'h18;
  localparam logic [6:0] OP_SEL      = 7'h41;
  localparam logic [6:0] OP_SEL_ATN  = 7'h42;
  localparam logic [6:0] OP_SEL_STOP = 7'h43;
  localparam logic [6:0] OP_EN_SEL   = 7'h44;
  localparam logic [6:0] OP_DIS_SEL  = 7'h45;

  localparam logic [7:0] IV_FUNC_DONE = 8'h08;
  localparam logic [7:0] IV_DISCON    = 8'h20;
  localparam logic [7:0] IV_RESET     = 8'h80;

  localparam int ST_INT = 7;
  localparam int ST_TC  = 4;
  localparam int CFG_NO_RST_RPT = 6;

  localparam logic [2:0] SEQ_DONE = 3'd4;
  localparam logic [7:0] CFG1_RST = 8'h07;

  typedef struct packed {
    logic       load_cnt;
    logic       hard_rst;
    logic       fifo_clear;
    logic       set_intr;
    logic [7:0] intr_val;
    logic       clr_seq;
    logic       raise;
    logic       pad;
    logic       seq_go;
  } cmd_act_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
`timescale 1ns/1ps
module scsi_cmd_decode
  import scsi_regs_pkg::*;
(
  input  logic [7:0] cmd,
  input  logic       rpt_off,
  output cmd_act_t   act
);

  always_comb begin
    act = '0;
    unique case (cmd[6:0])
      OP_FLUSH: begin
        act.fifo_clear = 1'b1;
        act.set_intr   = 1'b1;
        act.intr_val   = IV_FUNC_DONE;
        act.clr_seq    = 1'b1;
        act.raise      = 1'b1;
      end
      OP_CHIP_RST: act.hard_rst = 1'b1;
      OP_BUS_RST: begin
        act.set_intr = 1'b1;
        act.intr_val = IV_RESET;
        act.raise    = !rpt_off;
      end
      OP_MSG_ACC: begin
        act.fifo_clear = 1'b1;
        act.set_intr   = 1'b1;
        act.intr_val   = IV_DISCON;
        act.clr_seq    = 1'b1;
        act.raise      = 1'b1;
      end
      OP_PAD: begin
        act.pad      = 1'b1;
        act.set_intr = 1'b1;
        act.intr_val = IV_FUNC_DONE;
        act.clr_seq  = 1'b1;
        act.raise    = 1'b1;
      end
      OP_EN_SEL, OP_DIS_SEL: begin
        act.set_intr = 1'b1;
        act.intr_val = 8'h00;
      end
      OP_XFER, OP_SEL, OP_SEL_ATN, OP_SEL_STOP: act.seq_go = 1'b1;
      default: act = '0;
    endcase
    act.load_cnt = cmd[7] && !act.hard_rst;
  end

endmodule

// File: rtl/scsi_byte_fifo.sv
`timescale 1ns/1ps
module scsi_byte_fifo #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  output logic [CNT_W-1:0] count
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             push_ok, pop_ok;

  assign push_ok = push && (count < CNT_W'(DEPTH - 1));
  assign pop_ok  = pop && (count != '0);
  assign dout    = (count != '0) ? mem[rptr] : 8'h00;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= step(wptr);
      if (pop_ok)  rptr <= step(rptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clear) mem[wptr] <= din;
  end

endmodule

// File: rtl/scsi_host_regs.sv
`timescale 1ns/1ps
module scsi_host_regs
  import scsi_regs_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         SHIFT      = 2,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID    = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              acc_wide,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              seq_start,
  output logic [6:0]        seq_op,
  output logic              seq_dma
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_FIFO   = ADDR_W'(RI_FIFO);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(RI_CMD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(RI_STATUS);
  localparam logic [ADDR_W-1:0] A_INTR   = ADDR_W'(RI_INTR);
  localparam logic [ADDR_W-1:0] A_SEQ    = ADDR_W'(RI_SEQ);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(RI_FLAGS);
  localparam logic [ADDR_W-1:0] A_CFG1   = ADDR_W'(RI_CFG1);

  logic [ADDR_W-1:0]               reg_sel;
  logic                            wr_ok, rd_ok, cmd_wr, intr_rd;
  logic [CNT_BYTES-1:0][7:0]       cnt_wr, cnt_rd;
  logic [7:0]                      status, intr, cfg1, cmd_status, fifo_dout;
  logic [2:0]                      seq;
  logic [CNT_W-1:0]                fifo_count;
  cmd_act_t                        act;

  assign reg_sel = bus_addr >> SHIFT;
  assign wr_ok   = wr_en;
  assign rd_ok   = rd_en && !wr_en && !acc_wide;
  assign cmd_wr  = wr_ok && (reg_sel == A_CMD);
  assign intr_rd = rd_ok && (reg_sel == A_INTR);
  assign irq     = status[ST_INT];

  scsi_cmd_decode u_dec (
    .cmd     (wdata),
    .rpt_off (cfg1[CFG_NO_RST_RPT]),
    .act     (act)
  );

  scsi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_wr && (act.fifo_clear || act.hard_rst)),
    .push  (wr_ok && (reg_sel == A_FIFO)),
    .pop   (rd_ok && (reg_sel == A_FIFO)),
    .din   (wdata),
    .dout  (fifo_dout),
    .count (fifo_count)
  );

  // Counter bytes: staging (write view) and readable copy (read view).
  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
    localparam logic [7:0] RST_VAL = (b == CNT_BYTES - 1) ? CHIP_ID : 8'h00;
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(int'(RI_CNT_LO) + b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_wr[b] <= 8'h00;
        cnt_rd[b] <= RST_VAL;
      end else if (cmd_wr && act.hard_rst) begin
        cnt_wr[b] <= 8'h00;
        cnt_rd[b] <= RST_VAL;
      end else begin
        if (wr_ok && (reg_sel == A_BYTE)) cnt_wr[b] <= wdata;
        if (cmd_wr && act.load_cnt)       cnt_rd[b] <= cnt_wr[b];
      end
    end
  end

  always_comb begin
    cmd_status = status;
    cmd_status[ST_TC] = 1'b0;
    if (act.pad)   cmd_status = 8'(1 << ST_TC);
    if (act.raise) cmd_status[ST_INT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= 8'h00;
      intr      <= 8'h00;
      seq       <= 3'd0;
      cfg1      <= CFG1_RST;
      seq_start <= 1'b0;
      seq_op    <= 7'd0;
      seq_dma   <= 1'b0;
    end else begin
      seq_start <= 1'b0;
      if (cmd_wr) begin
        if (act.hard_rst) begin
          status <= 8'h00;
          intr   <= 8'h00;
          seq    <= 3'd0;
          cfg1   <= CFG1_RST;
        end else begin
          status <= cmd_status;
          if (act.set_intr) intr <= act.intr_val;
          if (act.clr_seq)  seq  <= 3'd0;
          if (act.seq_go) begin
            seq_start <= 1'b1;
            seq_op    <= wdata[6:0];
            seq_dma   <= wdata[7];
          end
        end
      end else if (wr_ok && (reg_sel == A_CFG1)) begin
        cfg1 <= wdata;
      end else if (intr_rd) begin
        intr           <= 8'h00;
        status[ST_TC]  <= 1'b0;
        status[ST_INT] <= 1'b0;
        seq            <= SEQ_DONE;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_ok) begin
      for (int b = 0; b < CNT_BYTES; b++)
        if (reg_sel == ADDR_W'(int'(RI_CNT_LO) + b)) rdata = cnt_rd[b];
      if (reg_sel == A_FIFO)   rdata = fifo_dout;
      if (reg_sel == A_STATUS) rdata = status;
      if (reg_sel == A_INTR)   rdata = intr;
      if (reg_sel == A_SEQ)    rdata = {5'd0, seq};
      if (reg_sel == A_FLAGS)  rdata = 8'(fifo_count);
      if (reg_sel == A_CFG1)   rdata = cfg1;
    end
  end

endmodule

// File: rtl/scsi_host_regs_chk.sv
`timescale 1ns/1ps
module scsi_host_regs_chk
  import scsi_regs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SHIFT      = 2,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   acc_wide,
  input logic [7:0]             wdata,
  input logic                   irq,
  input logic                   seq_start,
  input logic [CNT_W-1:0]       fifo_cnt,
  input logic [CNT_BYTES*8-1:0] cnt_rd,
  input logic [CNT_BYTES*8-1:0] cnt_wr
);

  logic [ADDR_W-1:0] sel;
  logic              byte_rd, cmd_wr;
  assign sel     = bus_addr >> SHIFT;
  assign byte_rd = rd_en && !wr_en && !acc_wide;
  assign cmd_wr  = wr_en && (sel == ADDR_W'(RI_CMD));

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH - 1));

  // R5
  intr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd && sel == ADDR_W'(RI_INTR)) |=> !irq);

  // R2
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7] && wdata[6:0] != OP_CHIP_RST) |=> cnt_rd == $past(cnt_wr));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cmd_wr));

  // R12
  seq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> $past(cmd_wr));

  // R13
  wide_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_wide && !wr_en) |=> ($stable(irq) && $stable(fifo_cnt)));

endmodule

bind scsi_host_regs scsi_host_regs_chk #(
  .ADDR_W(ADDR_W), .SHIFT(SHIFT), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
  .rd_en(rd_en), .acc_wide(acc_wide), .wdata(wdata), .irq(irq),
  .seq_start(seq_start), .fifo_cnt(fifo_count), .cnt_rd(cnt_rd),
  .cnt_wr(cnt_wr)
);

// File: tb/scsi_host_regs_test.sv
`timescale 1ns/1ps
module scsi_host_regs_test;

  localparam int         AW = 8;
  localparam int         SH = 2;
  localparam logic [7:0] CID = 8'h5A;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0, acc_wide = 1'b0;
  logic [7:0]    wdata = 8'h00, rdata;
  logic          irq, seq_start, seq_dma;
  logic [6:0]    seq_op;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  scsi_host_regs #(.ADDR_W(AW), .SHIFT(SH), .FIFO_DEPTH(16), .CHIP_ID(CID)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .acc_wide(acc_wide), .wdata(wdata), .rdata(rdata), .irq(irq),
    .seq_start(seq_start), .seq_op(seq_op), .seq_dma(seq_dma)
  );

  always #2 clk = ~clk;

  function automatic logic [AW-1:0] ra(input int idx);
    return AW'(idx << SH);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d, input logic wide);
    @(negedge clk);
    bus_addr = a; wdata = d; wr_en = 1'b1; acc_wide = wide;
    @(negedge clk);
    wr_en = 1'b0; acc_wide = 1'b0;
  endtask

  task automatic rd_raw(input logic [AW-1:0] a, input logic wide, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1; acc_wide = wide;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; acc_wide = 1'b0;
  endtask

  task automatic bw(input int idx, input logic [7:0] d);
    wr_raw(ra(idx), d, 1'b0);
  endtask

  task automatic expect_rd(input string req, input int idx, input logic [7:0] exp);
    logic [7:0] v;
    rd_raw(ra(idx), 1'b0, v);
    chk(req, int'(v), int'(exp));
  endtask

  // bench model for the random phase
  logic [7:0] m_wcnt [3];
  logic [7:0] m_rcnt [3];
  logic [7:0] m_q [$];

  function automatic logic [7:0] model_flags();
    return 8'(m_q.size());
  endfunction

  function automatic logic [7:0] model_pop();
    if (m_q.size() == 0) return 8'h00;
    return m_q.pop_front();
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    expect_rd("R1 cnt_lo", 0, 8'h00);
    expect_rd("R1 cnt_mid", 1, 8'h00);
    expect_rd("R1 cnt_hi", 2, CID);
    expect_rd("R1 cfg1", 9, 8'h07);
    expect_rd("R1 status", 5, 8'h00);
    expect_rd("R1 flags", 8, 8'h00);
    expect_rd("R1 intr", 6, 8'h00);

    // R2 staging vs readable counter
    bw(0, 8'h11); bw(1, 8'h22); bw(2, 8'h33);
    expect_rd("R2 no reload", 0, 8'h00);
    bw(4, 8'h00);
    expect_rd("R2 nop no dma", 2, CID);
    bw(4, 8'h80);
    chk("R12 nop no pulse", int'(seq_start), 0);
    expect_rd("R2 lo", 0, 8'h11);
    expect_rd("R2 mid", 1, 8'h22);
    expect_rd("R2 hi", 2, 8'h33);

    // R3 FIFO order and count
    bw(3, 8'hA1); bw(3, 8'hA2); bw(3, 8'hA3);
    expect_rd("R3 flags", 8, 8'h03);
    expect_rd("R3 pop", 3, 8'hA1);
    expect_rd("R3 flags after pop", 8, 8'h02);

    // R7 flush
    bw(4, 8'h01);
    chk("R7 irq", int'(irq), 1);
    expect_rd("R7 status", 5, 8'h80);
    expect_rd("R7 seq", 7, 8'h00);
    expect_rd("R7 flags", 8, 8'h00);
    // R5 acknowledge
    expect_rd("R5 intr value", 6, 8'h08);
    chk("R5 irq low", int'(irq), 0);
    expect_rd("R5 seq done", 7, 8'h04);
    expect_rd("R5 status", 5, 8'h00);
    expect_rd("R5 second read", 6, 8'h00);

    // R4 overrun
    for (int i = 0; i < 20; i++) bw(3, 8'h40 + 8'(i));
    expect_rd("R4 flags", 8, 8'h0F);
    for (int i = 0; i < 15; i++) expect_rd("R4 order", 3, 8'h40 + 8'(i));
    expect_rd("R4 empty pop", 3, 8'h00);
    expect_rd("R4 flags empty", 8, 8'h00);

    // R8 bus reset
    bw(4, 8'h03);
    chk("R8 irq reported", int'(irq), 1);
    expect_rd("R8 intr", 6, 8'h80);
    bw(9, 8'h47);
    bw(4, 8'h03);
    chk("R8 irq suppressed", int'(irq), 0);
    expect_rd("R8 intr suppressed", 6, 8'h80);

    // R12 enable/disable selection (cfg1 bit 6 still set)
    bw(4, 8'h03);
    bw(4, 8'h44);
    chk("R12 en_sel irq", int'(irq), 0);
    expect_rd("R12 en_sel intr", 6, 8'h00);
    bw(4, 8'h03);
    bw(4, 8'h45);
    chk("R12 dis_sel irq", int'(irq), 0);
    expect_rd("R12 dis_sel intr", 6, 8'h00);
    bw(9, 8'h07);

    // R9 message accept
    bw(3, 8'h99);
    bw(4, 8'h12);
    chk("R9 irq", int'(irq), 1);
    expect_rd("R9 seq", 7, 8'h00);
    expect_rd("R9 flags", 8, 8'h00);
    expect_rd("R9 intr", 6, 8'h20);

    // R10 pad
    bw(4, 8'h18);
    expect_rd("R10 status", 5, 8'h90);
    expect_rd("R10 seq", 7, 8'h00);
    bw(4, 8'h00);
    expect_rd("R10 tc cleared", 5, 8'h80);
    expect_rd("R10 intr", 6, 8'h08);
    expect_rd("R10 status acked", 5, 8'h00);

    // R12 sequencer pulses
    begin
      logic [6:0] ops [4] = '{7'h10, 7'h41, 7'h42, 7'h43};
      for (int i = 0; i < 4; i++) begin
        bw(4, {1'(i % 2), ops[i]});
        chk("R12 pulse", int'(seq_start), 1);
        chk("R12 op", int'(seq_op), int'(ops[i]));
        chk("R12 dma", int'(seq_dma), i % 2);
        @(negedge clk);
        chk("R12 pulse width", int'(seq_start), 0);
        chk("R12 no irq", int'(irq), 0);
      end
    end

    // R13 wide accesses and address shift
    bw(4, 8'h18);
    rd_raw(ra(6), 1'b1, v);
    chk("R13 wide read data", int'(v), 0);
    chk("R13 wide read no ack", int'(irq), 1);
    expect_rd("R13 intr after wide", 6, 8'h08);
    wr_raw(ra(0), 8'h77, 1'b1);
    bw(4, 8'h80);
    expect_rd("R13 wide write", 0, 8'h77);
    rd_raw(AW'(8'h0B), 1'b0, v);
    chk("R13 shifted addr", int'(v), 8'h33);
    wr_raw(ra(12), 8'hFF, 1'b0);
    rd_raw(ra(12), 1'b0, v);
    chk("R13 unimplemented", int'(v), 0);

    // R11 chip reset command
    bw(9, 8'h33); bw(3, 8'h55); bw(1, 8'h66); bw(4, 8'h80); bw(4, 8'h18);
    bw(4, 8'h02);
    chk("R11 irq", int'(irq), 0);
    expect_rd("R11 cfg1", 9, 8'h07);
    expect_rd("R11 cnt_mid", 1, 8'h00);
    expect_rd("R11 cnt_hi", 2, CID);
    expect_rd("R11 flags", 8, 8'h00);
    expect_rd("R11 status", 5, 8'h00);
    bw(4, 8'h80);
    expect_rd("R11 staging cleared", 1, 8'h00);

    // Random phase: counter, FIFO and command traffic against the model
    m_wcnt = '{8'h00, 8'h00, 8'h00};
    m_rcnt = '{8'h00, 8'h00, 8'h00};
    m_q.delete();
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 5));
      int b  = int'($urandom_range(0, 2));
      logic [7:0] d = 8'($urandom);
      case (op)
        0: begin bw(b, d); m_wcnt[b] = d; end
        1: begin bw(3, d); if (m_q.size() < 15) m_q.push_back(d); end
        2: expect_rd("R3 random pop", 3, model_pop());
        3: begin
             bw(4, {d[7], 7'h00});
             if (d[7]) m_rcnt = m_wcnt;
           end
        4: expect_rd("R2 random counter", b, m_rcnt[b]);
        default: expect_rd("R4 random flags", 8, model_flags());
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule